// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a byte address into a one-hot set of device chip selects, one for each of a parameterised number of regions (six by default). Every region owns a base value, a participation mask and an enable bit. An address falls into a region when all the address bits picked out by that region's mask agree with the same bits of its base. Bits that the mask leaves out are free. Because the mask is defined bit by bit, a region need not be a contiguous power-of-two window; aliased or interleaved patterns can be decoded.

Software or a boot sequencer fills the base, mask and enable values through a simple write port that selects a region by index and a register by a two-bit code. The bus side presents an address with an address-valid strobe. One clock edge later the chip-select vector and a no-match flag appear on registered outputs. When more than one region claims an address, the region with the smallest index wins.

Top module: `csel_decoder`

## Requirements
- R1: After reset `cs` is all zeros and `no_match` is low. Every region starts disabled with its mask and base cleared, so no address selects any region until that region is configured.
- R2: An address selects an enabled region when every address bit whose mask bit is 1 equals the same bit of that region's base.
- R3: Address bits whose mask bit is 0 have no influence on the match, including when the mask-1 bits are not contiguous.
- R4: A region whose enable bit is 0 never asserts its chip select, whatever its base and mask hold.
- R5: When several enabled regions match, only the lowest-numbered one has its bit set in `cs`.
- R6: `cs` is registered. It takes a new value at a clock edge only when `addr_valid` is high at that edge, and it holds its previous value otherwise.
- R7: `no_match` is registered and is high after an edge exactly when `addr_valid` was high at that edge and no enabled region matched. It is low after any edge where `addr_valid` was low.
- R8: A write with `cfg_we` high and `cfg_sel` = 0 loads the base of region `cfg_idx`. `cfg_sel` = 1 loads its mask, and `cfg_sel` = 2 loads its enable from `cfg_wdata[0]`. The new value applies to decodes at the following edges. Writes with `cfg_sel` = 3, or with `cfg_idx` at or beyond the region count, change nothing.
- R9: At most one bit of `cs` is set at any time, and `cs` is zero whenever `no_match` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (3) | Region index for the write |
| cfg_sel | input | 2 | Register code: 0 base, 1 mask, 2 enable, 3 reserved |
| cfg_wdata | input | ADDR_W (26) | Write data |
| addr_valid | input | 1 | Qualifies `addr` for decoding |
| addr | input | ADDR_W (26) | Byte address to decode |
| cs | output | N_REGION (6) | One-hot registered chip selects |
| no_match | output | 1 | Registered flag: valid address hit no region |

## Verification
The decoder is driven with addresses that hit a region compared on its upper bits only, and with addresses that miss that region by one bit. It also sees addresses that satisfy a two-bit non-contiguous mask while every free bit is toggled, which shows whether excluded bits leak into the compare. Overlapping regions, including a mask of all zeros that matches everything, show whether the lowest index wins. A configured but disabled region, together with writes to a reserved code and to an index past the last region, shows whether the enable gate and the write decoder filter correctly. Cycles with the valid strobe low, placed between hits, show the difference between holding the chip selects and clearing the no-match flag.

// File: rtl/csel_pkg.sv
// Shared definitions for the chip-select decoder.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package csel_pkg;

    // Register code carried on cfg_sel.
    typedef enum logic [1:0] {
        CFG_BASE   = 2'd0,
        CFG_MASK   = 2'd1,
        CFG_ENABLE = 2'd2,
        CFG_RSVD   = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/csel_cfg_bank.sv
// Per-region configuration storage: base, mask and enable for every region.
// Assumes: writes outside the region range or with the reserved code are
// dropped; everything clears on synchronous active-low reset.
module csel_cfg_bank
    import csel_pkg::*;
#(
    parameter int N_REGION = 6,
    parameter int ADDR_W   = 26,
    parameter int IDX_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 idx,
    input  cfg_sel_e                         sel,
    input  logic [ADDR_W-1:0]                wdata,
    output logic [N_REGION-1:0][ADDR_W-1:0]  base_o,
    output logic [N_REGION-1:0][ADDR_W-1:0]  mask_o,
    output logic [N_REGION-1:0]              en_o
);

    genvar r;
    generate
        for (r = 0; r < N_REGION; r++) begin : g_region
            logic hit_idx;

            // Decide whether the current write addresses this region.
            always_comb begin
                hit_idx = we && (idx == IDX_W'(r));
            end

            // Hold this region's base, mask and enable.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_o[r] <= '0;
                    mask_o[r] <= '0;
                    en_o[r]   <= 1'b0;
                end else if (hit_idx) begin
                    case (sel)
                        CFG_BASE:   base_o[r] <= wdata;
                        CFG_MASK:   mask_o[r] <= wdata;
                        CFG_ENABLE: en_o[r]   <= wdata[0];
                        default:    ;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/csel_match.sv
// Parallel masked comparison of one address against every region.
// Assumes: a region only reports a hit while enabled; mask bit 1 means the
// address bit takes part, mask bit 0 means it is ignored.
module csel_match #(
    parameter int N_REGION = 6,
    parameter int ADDR_W   = 26
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [N_REGION-1:0][ADDR_W-1:0]  base_i,
    input  logic [N_REGION-1:0][ADDR_W-1:0]  mask_i,
    input  logic [N_REGION-1:0]              en_i,
    output logic [N_REGION-1:0]              hit_o
);

    genvar r;
    generate
        for (r = 0; r < N_REGION; r++) begin : g_cmp
            logic [ADDR_W-1:0] diff;

            // Flag participating bits that disagree with the base.
            always_comb begin
                diff     = (addr ^ base_i[r]) & mask_i[r];
                hit_o[r] = en_i[r] && (diff == '0);
            end
        end
    endgenerate

endmodule

// File: rtl/csel_pick.sv
// Fixed-priority selector: keeps the lowest-indexed hit, drops the rest.
// Assumes: index 0 has the highest priority.
module csel_pick #(
    parameter int N_REGION = 6
) (
    input  logic [N_REGION-1:0] hit_i,
    output logic [N_REGION-1:0] grant_o,
    output logic                any_o
);

    // Scan upward and grant the first set bit found.
    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < N_REGION; i++) begin
            if (hit_i[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
        any_o = taken;
    end

endmodule

// File: rtl/csel_decoder.sv
// Top level: configurable base/mask chip-select decoder with registered
// one-hot selects and a no-match flag.
// Assumes: synchronous active-low reset; cs updates only on valid cycles;
// configuration written at an edge applies to decodes from the next edge.
module csel_decoder
    import csel_pkg::*;
#(
    parameter int N_REGION = 6,
    parameter int ADDR_W   = 26,
    parameter int IDX_W    = (N_REGION > 1) ? $clog2(N_REGION) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [1:0]          cfg_sel,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic                addr_valid,
    input  logic [ADDR_W-1:0]   addr,
    output logic [N_REGION-1:0] cs,
    output logic                no_match
);

    logic [N_REGION-1:0][ADDR_W-1:0] base_w;
    logic [N_REGION-1:0][ADDR_W-1:0] mask_w;
    logic [N_REGION-1:0]             en_w;
    logic [N_REGION-1:0]             hit_w;
    logic [N_REGION-1:0]             grant_w;
    logic                            any_w;
    cfg_sel_e                        sel_w;

    // Map the raw register code onto the shared enum.
    always_comb begin
        sel_w = cfg_sel_e'(cfg_sel);
    end

    csel_cfg_bank #(
        .N_REGION (N_REGION),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .idx    (cfg_idx),
        .sel    (sel_w),
        .wdata  (cfg_wdata),
        .base_o (base_w),
        .mask_o (mask_w),
        .en_o   (en_w)
    );

    csel_match #(
        .N_REGION (N_REGION),
        .ADDR_W   (ADDR_W)
    ) u_match (
        .addr   (addr),
        .base_i (base_w),
        .mask_i (mask_w),
        .en_i   (en_w),
        .hit_o  (hit_w)
    );

    csel_pick #(
        .N_REGION (N_REGION)
    ) u_pick (
        .hit_i   (hit_w),
        .grant_o (grant_w),
        .any_o   (any_w)
    );

    // Register the selects on valid cycles and the miss flag every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs       <= '0;
            no_match <= 1'b0;
        end else begin
            no_match <= addr_valid && !any_w;
            if (addr_valid) begin
                cs <= grant_w;
            end
        end
    end

endmodule

// File: rtl/csel_decoder_chk.sv
// Property checker for csel_decoder, bound into every instance.
// Assumes: sees the enable and raw-hit vectors of the bound instance.
module csel_decoder_chk #(
    parameter int N_REGION = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                addr_valid,
    input logic [N_REGION-1:0] cs,
    input logic                no_match,
    input logic [N_REGION-1:0] en,
    input logic [N_REGION-1:0] hit
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cs == '0) && !no_match);

    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && hit[0]) |=> cs[0]);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> $stable(cs));

    assert_idle_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> !no_match);

    assert_miss_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && hit == '0) |=> no_match);

    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));

    assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> (cs == '0));

    genvar r;
    generate
        for (r = 0; r < N_REGION; r++) begin : g_en
            assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (addr_valid && !en[r]) |=> !cs[r]);
        end
    endgenerate

endmodule

bind csel_decoder csel_decoder_chk #(.N_REGION(N_REGION)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_valid (addr_valid),
    .cs         (cs),
    .no_match   (no_match),
    .en         (en_w),
    .hit        (hit_w)
);

// File: tb/sim_csel_decoder.sv
module sim_csel_decoder;
    localparam int PERIOD = 10;
    localparam int NR  = 6;
    localparam int AW  = 26;
    localparam int IW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          addr_valid = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NR-1:0] cs;
    logic          no_match;

    csel_decoder #(.N_REGION(NR), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .addr_valid(addr_valid),
        .addr(addr), .cs(cs), .no_match(no_match)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        logic [NR-1:0] cs;
        logic          nm;
        string         req;
    } item_t;

    item_t         sb[$];
    int            n_chk = 0;
    int            n_bad = 0;
    logic [AW-1:0] m_base [NR];
    logic [AW-1:0] m_mask [NR];
    logic          m_en   [NR];
    logic [NR-1:0] m_held = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares each registered result one half-period after its edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(cs == it.cs, it.req, "cs", 32'(cs), 32'(it.cs));
            check(no_match == it.nm, it.req, "no_match", 32'(no_match), 32'(it.nm));
        end
    end

    task automatic cfg_write(input int idx, input int sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
        addr_valid = 1'b0;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (idx < NR) begin
            if (sel == 0) m_base[idx] = d;
            else if (sel == 1) m_mask[idx] = d;
            else if (sel == 2) m_en[idx] = d[0];
        end
        // write cycle had valid low: result is a hold with no flag (R6, R7)
        sb.push_back('{m_held, 1'b0, "R8"});
    endtask

    // Driver: presents one address and queues the expected registered result.
    task automatic decode(input logic v, input logic [AW-1:0] a, input string req);
        item_t it;
        logic [NR-1:0] g;
        g = '0;
        for (int i = NR - 1; i >= 0; i--)
            if (m_en[i] && (((a ^ m_base[i]) & m_mask[i]) == '0)) g = NR'(1) << i;
        @(negedge clk);
        addr_valid = v; addr = a;
        @(posedge clk);
        #1;
        if (v) m_held = g;
        it.cs = m_held;
        it.nm = v && (g == '0);
        it.req = req;
        sb.push_back(it);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_en[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cs == '0, "R1", "cs after reset", 32'(cs), 0);
        check(!no_match, "R1", "no_match after reset", 32'(no_match), 0);
        // R1: nothing configured, so any address misses
        decode(1'b1, 26'h0000000, "R1");
        decode(1'b1, 26'h3FFFFFF, "R1");
        // R2: region 2 compares on upper six bits
        cfg_write(2, 0, 26'h0100000);
        cfg_write(2, 1, 26'h3F00000);
        cfg_write(2, 2, 26'h1);
        decode(1'b1, 26'h0123456, "R2");
        decode(1'b1, 26'h0300000, "R2");
        decode(1'b1, 26'h01FFFFF, "R2");
        // R3: region 3 checks bits 25 and 0 only
        cfg_write(3, 0, 26'h2000001);
        cfg_write(3, 1, 26'h2000001);
        cfg_write(3, 2, 26'h1);
        decode(1'b1, 26'h2FFFFFF, "R3");
        decode(1'b1, 26'h2AAAAAB, "R3");
        decode(1'b1, 26'h2000000, "R3");
        decode(1'b1, 26'h0000001, "R3");
        // R4: region 1 configured but disabled
        cfg_write(1, 0, 26'h0040000);
        cfg_write(1, 1, 26'h3FC0000);
        decode(1'b1, 26'h0041234, "R4");
        cfg_write(1, 2, 26'h1);
        decode(1'b1, 26'h0041234, "R4");
        cfg_write(1, 2, 26'h0);
        decode(1'b1, 26'h0041234, "R4");
        // R5: region 0 with mask zero overlaps everything; region 2 overlaps region 4
        cfg_write(4, 0, 26'h0100000);
        cfg_write(4, 1, 26'h3000000);
        cfg_write(4, 2, 26'h1);
        decode(1'b1, 26'h0123456, "R5");
        decode(1'b1, 26'h0800000, "R5");
        cfg_write(0, 2, 26'h1);
        decode(1'b1, 26'h0123456, "R5");
        decode(1'b1, 26'h2FFFFFF, "R5");
        cfg_write(0, 2, 26'h0);
        // R6/R7: valid low holds cs and clears the flag
        decode(1'b1, 26'h2000001, "R6");
        decode(1'b0, 26'h0123456, "R6");
        decode(1'b0, 26'h0000000, "R6");
        decode(1'b1, 26'h0200000, "R7");
        decode(1'b0, 26'h0200000, "R7");
        decode(1'b1, 26'h0123456, "R6");
        // R8: reserved code and out-of-range index leave decoding unchanged
        cfg_write(2, 3, 26'h0000000);
        cfg_write(6, 2, 26'h1);
        cfg_write(7, 1, 26'h0000000);
        decode(1'b1, 26'h0123456, "R8");
        decode(1'b1, 26'h1000000, "R8");
        // R8/R9: mask reprogram applies on next decode
        cfg_write(3, 1, 26'h0000000);
        decode(1'b1, 26'h1000000, "R9");
        decode(1'b1, 26'h0123456, "R9");
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(sb.size() == 0, "R9", "scoreboard drained", 32'(sb.size()), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule